// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a register-programmed 2D drawing engine for a linear frame buffer. A host programs a source point, a destination point, a rectangle size, the two row pitches, the two base addresses, a fill colour and a control word. Writing the control word with its launch bit set starts one of two operations. A solid fill writes the fill colour into every pixel of the destination rectangle. A copy reads every pixel of the source rectangle and writes it to the matching pixel of the destination rectangle. Points and sizes are packed with the horizontal value in the upper halfword and the vertical value in the lower halfword.

The engine walks the rectangle one pixel at a time over a pixel-wide request interface. A request is held until it is granted, and read data is taken when the memory flags it valid. Each pixel address is the base plus the row times the pitch plus the column times the pixel size in bytes. When the host sets the reverse bit, both points name the bottom-right pixel and the walk runs from bottom-right towards top-left. This lets a copy between overlapping rectangles finish correctly when the source lies above the destination, or on the same row and to its left.

The controller has four states. IDLE waits for a launch. RD_REQ offers a read of the current source pixel. RD_WAIT waits for its data. WR_REQ offers a write of the current destination pixel. The transitions are as follows. IDLE goes to WR_REQ on a fill launch and to RD_REQ on a copy launch. RD_REQ goes to RD_WAIT on grant. RD_WAIT goes to WR_REQ on valid read data. On grant, WR_REQ goes to IDLE after the last pixel; otherwise it goes to WR_REQ for a fill or to RD_REQ for a copy.

Top module: `rect_blit_engine`

## Requirements
- R1: Registers at byte offsets 0x00 (source point), 0x04 (destination point), 0x08 (size, width in bits 31:16 and height in bits 15:0), 0x10 (pitch, destination pitch in bits 15:0 and source pitch in bits 31:16, in bytes), 0x14 (fill colour), 0x20 (source base) and 0x24 (destination base) read back the value last written.
- R2: The control register at 0x0C holds launch in bit 31, reverse in bit 27, pixel format in bits 21:20, command in bits 19:16 and the raster code in bits 7:0. It reads back everything that was written except bit 31, which always reads 0.
- R3: Bit 3 of the status register at 0x1C and the busy output rise on the clock edge after an accepted launch. They stay high until the clock edge that accepts the final write, and fall on that edge.
- R4: Command value 1 fills the destination rectangle with the low 24 bits of the fill colour and issues no reads.
- R5: Any other command value copies. Each pixel is read from the source and then written to the destination with the data that was read.
- R6: The pixel address is base + row*pitch + column*B, where B bytes are moved per request. Format codes 0 and 1 give B=1, 2 gives B=2 and 3 gives B=3, and mem_bytes carries B.
- R7: Without reverse, pixels are visited row by row from the given top-left point, with the column rising fastest.
- R8: With reverse, the points name the bottom-right pixels, and the column and row fall from them, with the column changing fastest.
- R9: An overlapping copy run in reverse, with the source above the destination, leaves the destination equal to the original source contents.
- R10: A launch with zero width or zero height makes no memory request and never raises busy.
- R11: Register writes made while busy, including a new launch, are ignored.
- R12: A request keeps mem_req, mem_we, mem_addr and mem_wdata steady until mem_gnt is seen, and read data is captured only on mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Pixel byte address |
| mem_bytes | output | 2 | Bytes per pixel in this request |
| mem_wdata | output | PIX_W | Pixel write data, byte 0 in bits 7:0 |
| mem_gnt | input | 1 | Request accepted at this edge |
| mem_rdata | input | PIX_W | Read pixel data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The assertions assume that the memory raises mem_rvalid only while a granted read is waiting for its data. They also assume it holds mem_rvalid for a single cycle per read, and that the host launches only after programming the size. The bench memory keeps to this. It returns data one or two cycles after each granted read and never otherwise. It varies the grant pattern so that requests wait for zero or one cycle. Register writes are issued only between clock edges, so a launch never coincides with a reset.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ
    } blit_state_e;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFF_SRC_PT   = 6'h00;
    localparam logic [REG_AW-1:0] OFF_DST_PT   = 6'h04;
    localparam logic [REG_AW-1:0] OFF_EXTENT   = 6'h08;
    localparam logic [REG_AW-1:0] OFF_CTRL     = 6'h0C;
    localparam logic [REG_AW-1:0] OFF_PITCH    = 6'h10;
    localparam logic [REG_AW-1:0] OFF_FG       = 6'h14;
    localparam logic [REG_AW-1:0] OFF_STATUS   = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_SRC_BASE = 6'h20;
    localparam logic [REG_AW-1:0] OFF_DST_BASE = 6'h24;

    localparam int CTL_GO     = 31;
    localparam int CTL_REV    = 27;
    localparam int CTL_FMT_LO = 20;
    localparam int CTL_CMD_LO = 16;
    localparam int STS_BUSY   = 3;

    localparam logic [3:0] CMD_FILL = 4'd1;

    // format code to bytes per pixel: 0 and 1 -> 1, 2 -> 2, 3 -> 3
    function automatic logic [1:0] fmt_bytes(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy_i,
    output logic [31:0]       src_pt,
    output logic [31:0]       dst_pt,
    output logic [31:0]       extent,
    output logic [31:0]       pitch,
    output logic [PIX_W-1:0]  fg_pix,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic              fill,
    output logic              rev,
    output logic [1:0]        bpp,
    output logic              go_o,
    output logic              go_fill_o
);

    logic [31:0] ctrl_q;
    logic [31:0] fg_q;
    logic        wr_ok;
    logic        start_wr;

    assign wr_ok     = reg_we && !busy_i;
    assign start_wr  = wr_ok && (reg_addr == OFF_CTRL) && reg_wdata[CTL_GO];
    assign go_o      = start_wr && (extent[31:16] != 16'd0) && (extent[15:0] != 16'd0);
    assign go_fill_o = (reg_wdata[CTL_CMD_LO +: 4] == CMD_FILL);

    assign fill   = (ctrl_q[CTL_CMD_LO +: 4] == CMD_FILL);
    assign rev    = ctrl_q[CTL_REV];
    assign bpp    = fmt_bytes(ctrl_q[CTL_FMT_LO +: 2]);
    assign fg_pix = fg_q[PIX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_pt   <= '0;
            dst_pt   <= '0;
            extent   <= '0;
            pitch    <= '0;
            ctrl_q   <= '0;
            fg_q     <= '0;
            src_base <= '0;
            dst_base <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFF_SRC_PT:   src_pt   <= reg_wdata;
                OFF_DST_PT:   dst_pt   <= reg_wdata;
                OFF_EXTENT:   extent   <= reg_wdata;
                OFF_PITCH:    pitch    <= reg_wdata;
                OFF_CTRL:     ctrl_q   <= {1'b0, reg_wdata[30:0]};
                OFF_FG:       fg_q     <= reg_wdata;
                OFF_SRC_BASE: src_base <= reg_wdata[ADDR_W-1:0];
                OFF_DST_BASE: dst_base <= reg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_SRC_PT:   reg_rdata = src_pt;
            OFF_DST_PT:   reg_rdata = dst_pt;
            OFF_EXTENT:   reg_rdata = extent;
            OFF_PITCH:    reg_rdata = pitch;
            OFF_CTRL:     reg_rdata = ctrl_q;
            OFF_FG:       reg_rdata = fg_q;
            OFF_STATUS:   reg_rdata[STS_BUSY] = busy_i;
            OFF_SRC_BASE: reg_rdata = 32'(src_base);
            OFF_DST_BASE: reg_rdata = 32'(dst_base);
            default:      reg_rdata = '0;
        endcase
    end

    // R11: nothing programmed changes while an operation runs
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && busy_i) |=> ($stable(ctrl_q) && $stable(fg_q) && $stable(extent) && $stable(src_pt) && $stable(dst_pt)));

endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [15:0]       pitch,
    input  logic [31:0]       org,
    input  logic [15:0]       cx,
    input  logic [15:0]       cy,
    input  logic              rev,
    input  logic [1:0]        bpp,
    output logic [ADDR_W-1:0] addr
);

    logic [15:0] px;
    logic [15:0] py;
    logic [31:0] row_off;
    logic [31:0] col_off;

    always_comb begin
        px      = rev ? (org[31:16] - cx) : (org[31:16] + cx);
        py      = rev ? (org[15:0]  - cy) : (org[15:0]  + cy);
        row_off = 32'(py) * 32'(pitch);
        col_off = 32'(px) * 32'(bpp);
        addr    = base + ADDR_W'(row_off) + ADDR_W'(col_off);
    end

endmodule

// File: rtl/blit_fsm.sv
module blit_fsm
    import blit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_fill,
    input  logic              fill_i,
    input  logic [31:0]       extent,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [PIX_W-1:0]  fg,
    input  logic [1:0]        bpp,
    output logic [15:0]       cx,
    output logic [15:0]       cy,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_bytes,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_gnt,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_rvalid
);

    blit_state_e      state, nxt;
    logic [PIX_W-1:0] pix_q;
    logic [15:0]      w, h;
    logic             row_end, last;

    assign w       = extent[31:16];
    assign h       = extent[15:0];
    assign row_end = (cx == w - 16'd1);
    assign last    = row_end && (cy == h - 16'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cx    <= '0;
            cy    <= '0;
            pix_q <= '0;
        end else begin
            state <= nxt;
            if (go) begin
                cx <= '0;
                cy <= '0;
            end else if (state == ST_WR_REQ && mem_gnt && !last) begin
                cx <= row_end ? 16'd0 : cx + 16'd1;
                cy <= row_end ? cy + 16'd1 : cy;
            end
            if (state == ST_RD_WAIT && mem_rvalid)
                pix_q <= mem_rdata;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go) nxt = go_fill ? ST_WR_REQ : ST_RD_REQ;
            ST_RD_REQ:  if (mem_gnt) nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) nxt = ST_WR_REQ;
            ST_WR_REQ:  if (mem_gnt) nxt = last ? ST_IDLE : (fill_i ? ST_WR_REQ : ST_RD_REQ);
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_addr;
        mem_bytes = bpp;
        mem_wdata = fill_i ? fg : pix_q;
        unique case (state)
            ST_IDLE: ;
            ST_RD_REQ: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = src_addr;
            end
            ST_RD_WAIT: busy = 1'b1;
            ST_WR_REQ: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // R12: an ungranted request holds steady
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R3: requests only appear during an operation
    a_r3_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R3: a launch raises busy on the next edge
    a_r3_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R4: a fill never reads
    a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_i && mem_req) |-> mem_we);

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_bytes,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_gnt,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_rvalid
);

    localparam int NPORT = 2;   // 0 = source, 1 = destination

    logic [31:0]       src_pt, dst_pt, extent, pitch;
    logic [PIX_W-1:0]  fg_pix;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic              fill, rev, go, go_fill;
    logic [1:0]        bpp;
    logic [15:0]       cx, cy;

    logic [ADDR_W-1:0] base_a  [NPORT];
    logic [31:0]       org_a   [NPORT];
    logic [15:0]       pitch_a [NPORT];
    logic [ADDR_W-1:0] addr_a  [NPORT];

    blit_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy),
        .src_pt(src_pt), .dst_pt(dst_pt), .extent(extent), .pitch(pitch),
        .fg_pix(fg_pix), .src_base(src_base), .dst_base(dst_base),
        .fill(fill), .rev(rev), .bpp(bpp), .go_o(go), .go_fill_o(go_fill)
    );

    assign base_a[0]  = src_base;
    assign base_a[1]  = dst_base;
    assign org_a[0]   = src_pt;
    assign org_a[1]   = dst_pt;
    assign pitch_a[0] = pitch[31:16];
    assign pitch_a[1] = pitch[15:0];

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        blit_addr #(.ADDR_W(ADDR_W)) u_addr (
            .base(base_a[g]), .pitch(pitch_a[g]), .org(org_a[g]),
            .cx(cx), .cy(cy), .rev(rev), .bpp(bpp), .addr(addr_a[g])
        );
    end

    blit_fsm #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_fill(go_fill), .fill_i(fill), .extent(extent),
        .src_addr(addr_a[0]), .dst_addr(addr_a[1]), .fg(fg_pix), .bpp(bpp),
        .cx(cx), .cy(cy), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // R10: a launch on an empty rectangle leaves the engine idle
    a_r10_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == OFF_CTRL && reg_wdata[CTL_GO] &&
         (extent[31:16] == 16'd0 || extent[15:0] == 16'd0)) |=> (!busy && !mem_req));

    // R3: a launch on a non-empty rectangle raises busy
    a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == OFF_CTRL && reg_wdata[CTL_GO] &&
         extent[31:16] != 16'd0 && extent[15:0] != 16'd0) |=> busy);

endmodule

// File: tb/rect_blit_engine_bench.sv
module rect_blit_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ      = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_bytes;
    logic [23:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_blit_engine u_rect_blit_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural memory and reference model
    logic [7:0] mem_b [MEMSZ];
    logic [7:0] shd   [MEMSZ];
    int    q_we[$];
    int    q_addr[$];
    int    q_data[$];
    int    op_bytes = 1;
    string cur_tag = "";
    bit    accept_now = 0;
    int    cyc = 0;
    int    rd_pend = 0;
    int    rd_data = 0;
    bit    prev_wait = 0;
    int    prev_addr = 0;

    function automatic int bmask(input int nb);
        return (1 << (8 * nb)) - 1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            mem_rvalid = 1'b0;
            if (rd_pend > 0) begin
                rd_pend--;
                if (rd_pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = 24'(rd_data);
                end
            end
            mem_gnt = ((cyc % 3) != 1);
            if (prev_wait)
                check(mem_req && int'(mem_addr) == prev_addr, "R12 held request", int'(mem_addr), prev_addr);
            prev_wait  = mem_req && !mem_gnt;
            prev_addr  = int'(mem_addr);
            accept_now = 0;
            if (mem_req && mem_gnt) begin
                accept_now = 1;
                if (q_we.size() == 0) begin
                    check(0, "R10 R11 unexpected access", int'(mem_addr), 0);
                end else begin
                    int e_we, e_addr, e_data;
                    e_we   = q_we.pop_front();
                    e_addr = q_addr.pop_front();
                    e_data = q_data.pop_front();
                    check(int'(mem_we) == e_we, {cur_tag, " direction"}, int'(mem_we), e_we);
                    check(int'(mem_addr) == e_addr, {cur_tag, " address"}, int'(mem_addr), e_addr);
                    check(int'(mem_bytes) == op_bytes, "R6 bytes", int'(mem_bytes), op_bytes);
                    if (mem_we) begin
                        int v;
                        v = int'(mem_wdata) & bmask(op_bytes);
                        check(v == e_data, {cur_tag, " data"}, v, e_data);
                        for (int b = 0; b < op_bytes; b++)
                            mem_b[(int'(mem_addr) + b) % MEMSZ] = 8'((v >> (8 * b)) & 255);
                    end else begin
                        rd_data = 0;
                        for (int b = 0; b < op_bytes; b++)
                            rd_data |= int'(mem_b[(int'(mem_addr) + b) % MEMSZ]) << (8 * b);
                        rd_pend = 1 + (cyc % 2);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R3 actual=busy expected=idle");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic wr(input logic [5:0] a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    function automatic int ctl(input bit go, input bit rv, input int fmt, input int cmd);
        return (int'(go) << 31) | (int'(rv) << 27) | (fmt << 20) | (cmd << 16) | 32'h0C;
    endfunction

    task automatic build_op(input bit fill, input bit rv, input int nb,
                            input int sb, input int db, input int sp, input int dp,
                            input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h, input int fg);
        for (int i = 0; i < MEMSZ; i++) shd[i] = mem_b[i];
        op_bytes = nb;
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int xs, ys, xd, yd, sa, da, v;
                xs = rv ? sx - x : sx + x;
                ys = rv ? sy - y : sy + y;
                xd = rv ? dx - x : dx + x;
                yd = rv ? dy - y : dy + y;
                sa = sb + ys * sp + xs * nb;
                da = db + yd * dp + xd * nb;
                if (fill) begin
                    v = fg & bmask(nb);
                end else begin
                    v = 0;
                    for (int b = 0; b < nb; b++) v |= int'(shd[(sa + b) % MEMSZ]) << (8 * b);
                    q_we.push_back(0); q_addr.push_back(sa); q_data.push_back(0);
                end
                for (int b = 0; b < nb; b++) shd[(da + b) % MEMSZ] = 8'((v >> (8 * b)) & 255);
                q_we.push_back(1); q_addr.push_back(da); q_data.push_back(v);
            end
        end
    endtask

    task automatic wait_op();
        int guard = 0;
        int e;
        do begin
            @(negedge clk);
            #2;
            e = ((q_we.size() > 0) || accept_now) ? 1 : 0;
            check(int'(busy) == e, "R3 busy tracking", int'(busy), e);
            guard++;
        end while ((q_we.size() > 0 || busy) && guard < 4000);
    endtask

    initial begin
        int v;
        int snap [48];
        int bad;
        for (int i = 0; i < MEMSZ; i++) mem_b[i] = 8'((i * 7 + 3) & 255);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk); #1;
        check(busy == 1'b0, "R3 reset busy", int'(busy), 0);
        check(mem_req == 1'b0, "R12 reset request", int'(mem_req), 0);
        rd(6'h1C, v); check(v == 0, "R3 reset status", v, 0);
        rd(6'h0C, v); check(v == 0, "R2 reset control", v, 0);

        // R1 register readback
        wr(6'h00, 32'h0003_0002); rd(6'h00, v); check(v == 32'h0003_0002, "R1 source point", v, 32'h0003_0002);
        wr(6'h04, 32'h0004_0005); rd(6'h04, v); check(v == 32'h0004_0005, "R1 destination point", v, 32'h0004_0005);
        wr(6'h08, 32'h0000_0000); rd(6'h08, v); check(v == 0, "R1 size", v, 0);
        wr(6'h10, 32'h0040_0050); rd(6'h10, v); check(v == 32'h0040_0050, "R1 pitch", v, 32'h0040_0050);
        wr(6'h14, 32'h11A5C3E7); rd(6'h14, v); check(v == 32'h11A5C3E7, "R1 fill colour", v, 32'h11A5C3E7);
        wr(6'h20, 32'h0000_0800); rd(6'h20, v); check(v == 32'h800, "R1 source base", v, 32'h800);
        wr(6'h24, 32'h0000_0200); rd(6'h24, v); check(v == 32'h200, "R1 destination base", v, 32'h200);

        // R4 R6 R7: one-byte fill, 4x3 at (3,2), pitch 40
        cur_tag = "R4 R6 R7 fill";
        wr(6'h10, 32'h0040_0028);
        wr(6'h04, 32'h0003_0002);
        wr(6'h08, 32'h0004_0003);
        build_op(1, 0, 1, 32'h800, 32'h200, 64, 40, 0, 0, 3, 2, 4, 3, 32'h11A5C3E7);
        wr(6'h0C, ctl(1, 0, 1, 1));
        wait_op();

        // R4 R6: three-byte fill, 3x2 at (1,1)
        cur_tag = "R4 R6 wide fill";
        wr(6'h14, 32'h0012_3456);
        wr(6'h04, 32'h0001_0001);
        wr(6'h08, 32'h0003_0002);
        build_op(1, 0, 3, 32'h800, 32'h200, 64, 40, 0, 0, 1, 1, 3, 2, 32'h123456);
        wr(6'h0C, ctl(1, 0, 3, 1));
        wait_op();

        // R5 R6 R7: forward copy with command 2, two bytes, different pitches
        cur_tag = "R5 R6 R7 copy";
        wr(6'h10, 32'h0040_0050);
        wr(6'h24, 32'h0000_1000);
        wr(6'h00, 32'h0002_0001);
        wr(6'h04, 32'h0005_0003);
        wr(6'h08, 32'h0005_0003);
        build_op(0, 0, 2, 32'h800, 32'h1000, 64, 80, 2, 1, 5, 3, 5, 3, 0);
        wr(6'h0C, ctl(1, 0, 2, 2));
        wait_op();

        // R8 R9: overlapping reverse copy, top-left (2,2) -> (4,3), 6x4, two bytes
        cur_tag = "R8 reverse copy";
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 6; x++)
                snap[y * 6 + x] = int'(mem_b[32'h100 + (2 + y) * 64 + (2 + x) * 2])
                                | (int'(mem_b[32'h100 + (2 + y) * 64 + (2 + x) * 2 + 1]) << 8);
        wr(6'h10, 32'h0040_0040);
        wr(6'h20, 32'h0000_0100);
        wr(6'h24, 32'h0000_0100);
        wr(6'h00, 32'h0007_0005);
        wr(6'h04, 32'h0009_0006);
        wr(6'h08, 32'h0006_0004);
        build_op(0, 1, 2, 32'h100, 32'h100, 64, 64, 7, 5, 9, 6, 6, 4, 0);
        wr(6'h0C, ctl(1, 1, 2, 0));
        wait_op();
        bad = 0;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 6; x++) begin
                v = int'(mem_b[32'h100 + (3 + y) * 64 + (4 + x) * 2])
                  | (int'(mem_b[32'h100 + (3 + y) * 64 + (4 + x) * 2 + 1]) << 8);
                if (v != snap[y * 6 + x]) bad++;
            end
        check(bad == 0, "R9 overlap result mismatching pixels", bad, 0);
        rd(6'h0C, v);
        check(v == ctl(0, 1, 2, 0), "R2 launch bit self-clears", v, ctl(0, 1, 2, 0));

        // R10: zero width, then zero height
        cur_tag = "R10 zero size";
        wr(6'h08, 32'h0000_0003);
        wr(6'h0C, ctl(1, 0, 1, 1));
        bad = 0;
        repeat (10) begin @(negedge clk); #2; if (busy) bad++; end
        check(bad == 0, "R10 zero width busy cycles", bad, 0);
        wr(6'h08, 32'h0005_0000);
        wr(6'h0C, ctl(1, 0, 1, 0));
        bad = 0;
        repeat (10) begin @(negedge clk); #2; if (busy || mem_req) bad++; end
        check(bad == 0, "R10 zero height busy cycles", bad, 0);

        // R11: writes during an operation are dropped
        cur_tag = "R11 copy under writes";
        wr(6'h14, 32'h0000_4242);
        wr(6'h20, 32'h0000_0800);
        wr(6'h24, 32'h0000_1400);
        wr(6'h00, 32'h0000_0000);
        wr(6'h04, 32'h0001_0001);
        wr(6'h08, 32'h0004_0002);
        build_op(0, 0, 1, 32'h800, 32'h1400, 64, 64, 0, 0, 1, 1, 4, 2, 0);
        wr(6'h0C, ctl(1, 0, 1, 0));
        wr(6'h0C, ctl(1, 0, 3, 1));
        wr(6'h14, 32'h00FF_FFFF);
        wait_op();
        rd(6'h14, v); check(v == 32'h4242, "R11 colour unchanged", v, 32'h4242);
        rd(6'h0C, v); check(v == ctl(0, 0, 1, 0), "R11 control unchanged", v, ctl(0, 0, 1, 0));
        repeat (6) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule